// File: doc/BRIEF.md
# Cascaded Dual-Channel Capture Timer

The block is a free-running 32-bit up-counter split into two 16-bit halves. The lower half advances on every clock where the count enable is high. The upper half advances by one only when the lower half wraps from all ones to zero. Two capture channels sit beside the counter. The upper channel latches the upper half and the lower channel latches the lower half, so when both fire together their registers hold a single 32-bit snapshot of the count.

Each channel watches a capture pin. The pin first passes through a two-flop synchronizer. A per-channel select chooses which transitions of the channel's trigger signal count as a capture event: none, rising, falling or both. Each channel also has a cross-inclusion bit. When that bit is set, the channel's trigger becomes the OR of its own pin and the other channel's pin. With both bits set, one edge on the ORed signal captures both halves at once. While either pin is high the ORed signal cannot change, so an edge on the other pin is not seen.

Top module: `cascade_capture_timer`

## Requirements
- R1: When `cnt_en` is high, `cnt_lo` increases by one on each clock. When `cnt_en` is low, both count halves keep their values.
- R2: On an enabled clock where `cnt_lo` is 16'hFFFF, `cnt_lo` becomes 0 and `cnt_hi` increases by one. On no other clock does `cnt_hi` change.
- R3: After a clock with `rst` high, both count halves, both capture registers and both flags are zero.
- R4: A capture loads the channel's register with the count half it owns, taken as it stood before that clock's increment. A capture on the wrap clock therefore stores 16'hFFFF in the lower register and the upper value from before the carry.
- R5: The trigger of the upper channel is `cap_pin_hi`, ORed with `cap_pin_lo` when `incl_lo_into_hi` is 1. The trigger of the lower channel is `cap_pin_lo`, ORed with `cap_pin_hi` when `incl_hi_into_lo` is 1.
- R6: The edge select is 2 bits per channel: 2'b00 disables capture, 2'b01 captures on a rising trigger, 2'b10 on a falling trigger, 2'b11 on either.
- R7: While one pin that feeds an ORed trigger is high, a transition on the other pin that feeds it causes no capture.
- R8: A pin change drives at the third rising clock edge after it, since it passes two synchronizer flops and then the capture register. The capture flag is high for exactly the one cycle after the register updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| cap_pin_lo | input | 1 | Asynchronous capture pin of the lower channel |
| cap_pin_hi | input | 1 | Asynchronous capture pin of the upper channel |
| incl_lo_into_hi | input | 1 | Adds the lower pin to the upper channel's trigger |
| incl_hi_into_lo | input | 1 | Adds the upper pin to the lower channel's trigger |
| edge_sel_lo | input | 2 | Edge select of the lower channel |
| edge_sel_hi | input | 2 | Edge select of the upper channel |
| cnt_lo | output | 16 | Lower count half |
| cnt_hi | output | 16 | Upper count half |
| capt_lo | output | 16 | Lower capture register |
| capt_hi | output | 16 | Upper capture register |
| capt_flag_lo | output | 1 | One-cycle pulse when `capt_lo` loads |
| capt_flag_hi | output | 1 | One-cycle pulse when `capt_hi` loads |

## Verification
The bench raises and drops the second pin while the first is high. A design that edge-detected each pin on its own and then ORed the results would capture on those masked transitions. It runs the counter to the lower wrap and lands a capture on that exact clock. A design that sampled after the increment would store 0 and a carried upper half, which is a torn snapshot. It sets the two inclusion bits to different values and gives each channel its own edge mode. A swapped select wire, a mixed-up inclusion bit or a wrong edge polarity then shows up as a flag on the wrong channel. It also checks for a flag one cycle early, which would mean a synchronizer stage is missing, and checks that the counter freezes when the enable is low.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Decide whether a trigger transition qualifies under the chosen mode.
  function automatic logic edge_hit(input logic [1:0] sel,
                                    input logic cur,
                                    input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (edge_mode_e'(sel))
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // Capture trigger: own pin, optionally ORed with the neighbour pin.
  function automatic logic trig_of(input logic own, input logic other,
                                   input logic incl);
    trig_of = own | (incl & other);
  endfunction

endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic              lo_wrap
);
  localparam logic [HALF_W-1:0] HALF_MAX = '1;
  localparam logic [HALF_W-1:0] ONE      = HALF_W'(1);

  assign lo_wrap = cnt_en && (cnt_lo == HALF_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (cnt_en) begin
      cnt_lo <= cnt_lo + ONE;
      if (lo_wrap) cnt_hi <= cnt_hi + ONE;
    end
  end

  // R1
  lo_step_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (cnt_lo == $past(cnt_lo) + ONE));
  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  // R2
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_lo == HALF_MAX) |=> (cnt_hi == $past(cnt_hi) + ONE && cnt_lo == '0));
  // R2
  no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !(cnt_en && cnt_lo == HALF_MAX) |=> $stable(cnt_hi));
endmodule

// File: rtl/cct_capture_ch.sv
module cct_capture_ch #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_sync,
  input  logic              other_sync,
  input  logic              incl,
  input  logic [1:0]        sel,
  input  logic [HALF_W-1:0] count_in,
  output logic              hit,
  output logic [HALF_W-1:0] capt,
  output logic              flag
);
  logic trig;
  logic trig_prev;

  assign trig = cct_pkg::trig_of(own_sync, other_sync, incl);
  assign hit  = cct_pkg::edge_hit(sel, trig, trig_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_prev <= 1'b0;
      capt      <= '0;
      flag      <= 1'b0;
    end else begin
      trig_prev <= trig;
      flag      <= hit;
      if (hit) capt <= count_in;
    end
  end

  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (capt == $past(count_in) && flag));
  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(capt) && !flag));
  // R7
  masked_chk: assert property (@(posedge clk) disable iff (rst)
    (own_sync && $past(own_sync) && incl && $past(incl)) |-> !hit);
  // R5
  solo_chk: assert property (@(posedge clk) disable iff (rst)
    (!incl && $past(!incl) && $stable(own_sync)) |-> !hit);
  // R6
  off_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> !hit);
endmodule

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer #(
  parameter int HALF_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              cap_pin_lo,
  input  logic              cap_pin_hi,
  input  logic              incl_lo_into_hi,
  input  logic              incl_hi_into_lo,
  input  logic [1:0]        edge_sel_lo,
  input  logic [1:0]        edge_sel_hi,
  output logic [HALF_W-1:0] cnt_lo,
  output logic [HALF_W-1:0] cnt_hi,
  output logic [HALF_W-1:0] capt_lo,
  output logic [HALF_W-1:0] capt_hi,
  output logic              capt_flag_lo,
  output logic              capt_flag_hi
);
  logic sync_lo;
  logic sync_hi;
  logic lo_wrap;
  logic hit_lo;
  logic hit_hi;

  cct_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
    .clk(clk), .rst(rst), .d(cap_pin_lo), .q(sync_lo));
  cct_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
    .clk(clk), .rst(rst), .d(cap_pin_hi), .q(sync_hi));

  cct_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .lo_wrap(lo_wrap));

  cct_capture_ch #(.HALF_W(HALF_W)) u_ch_lo (
    .clk(clk), .rst(rst), .own_sync(sync_lo), .other_sync(sync_hi),
    .incl(incl_hi_into_lo), .sel(edge_sel_lo), .count_in(cnt_lo),
    .hit(hit_lo), .capt(capt_lo), .flag(capt_flag_lo));

  cct_capture_ch #(.HALF_W(HALF_W)) u_ch_hi (
    .clk(clk), .rst(rst), .own_sync(sync_hi), .other_sync(sync_lo),
    .incl(incl_lo_into_hi), .sel(edge_sel_hi), .count_in(cnt_hi),
    .hit(hit_hi), .capt(capt_hi), .flag(capt_flag_hi));

  // R4
  torn_snap_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && hit_hi && lo_wrap) |=> (capt_lo == '1 && capt_hi == cnt_hi - HALF_W'(1)));
  // R3
  reset_chk: assert property (@(posedge clk)
    rst |=> (cnt_lo == '0 && cnt_hi == '0 && capt_lo == '0 && capt_hi == '0
             && !capt_flag_lo && !capt_flag_hi));
endmodule

// File: tb/cascade_capture_timer_tb.sv
`timescale 1ns/1ps
module cascade_capture_timer_tb;
  logic clk = 1'b0;
  logic rst, cnt_en, cap_pin_lo, cap_pin_hi, incl_lo_into_hi, incl_hi_into_lo;
  logic [1:0] edge_sel_lo, edge_sel_hi;
  logic [15:0] cnt_lo, cnt_hi, capt_lo, capt_hi;
  logic capt_flag_lo, capt_flag_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cascade_capture_timer u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .cap_pin_lo(cap_pin_lo), .cap_pin_hi(cap_pin_hi),
    .incl_lo_into_hi(incl_lo_into_hi), .incl_hi_into_lo(incl_hi_into_lo),
    .edge_sel_lo(edge_sel_lo), .edge_sel_hi(edge_sel_hi),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .capt_lo(capt_lo), .capt_hi(capt_hi),
    .capt_flag_lo(capt_flag_lo), .capt_flag_hi(capt_flag_hi));

  // fields: [9] incl_lo_into_hi [8] incl_hi_into_lo [7:6] sel_hi [5:4] sel_lo
  //         [3] pin_lo [2] pin_hi [1] expect hi capture [0] expect lo capture
  localparam int NV = 12;
  localparam logic [9:0] VEC [NV] = '{
    10'b11_11_11_10_11,  // R5 ORed rise captures both
    10'b11_11_11_11_00,  // R7 hi rises under high lo: masked
    10'b11_11_11_01_00,  // R7 lo falls under high hi: masked
    10'b11_11_11_00_11,  // R6 both-edges: OR falls captures both
    10'b11_01_10_01_10,  // R6 rise mode hi only
    10'b11_01_10_00_01,  // R6 fall mode lo only
    10'b00_11_11_10_01,  // R5 no inclusion: lo pin to lo channel only
    10'b00_11_11_11_10,  // R5 no inclusion: hi pin to hi channel only
    10'b00_00_00_00_00,  // R6 disabled: no capture on falls
    10'b10_11_11_01_10,  // R5 hi pin does not reach lo channel
    10'b10_11_11_11_01,  // R5 R7 lo channel sees own rise, hi trigger masked
    10'b10_11_11_10_00   // R7 hi pin falls while lo high: hi trigger stays
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    logic [15:0] old_lo, old_hi, h0, l0;
    logic [31:0] snap;
    rst = 1'b1; cnt_en = 1'b0; cap_pin_lo = 1'b0; cap_pin_hi = 1'b0;
    incl_lo_into_hi = 1'b0; incl_hi_into_lo = 1'b0;
    edge_sel_lo = 2'b00; edge_sel_hi = 2'b00;
    repeat (3) @(negedge clk);
    // R3 reset state
    check(cnt_lo == 0 && cnt_hi == 0, "R3 counters", {cnt_hi, cnt_lo}, 0);
    check(capt_lo == 0 && capt_hi == 0, "R3 captures", {capt_hi, capt_lo}, 0);
    check(!capt_flag_lo && !capt_flag_hi, "R3 flags", {capt_flag_hi, capt_flag_lo}, 0);
    rst = 1'b0; cnt_en = 1'b1;
    repeat (4) @(negedge clk);
    // R1 counting
    l0 = cnt_lo;
    @(negedge clk);
    check(cnt_lo == l0 + 16'd1, "R1 step", cnt_lo, l0 + 16'd1);

    for (int i = 0; i < NV; i++) begin
      old_lo = capt_lo; old_hi = capt_hi;
      incl_lo_into_hi = VEC[i][9]; incl_hi_into_lo = VEC[i][8];
      edge_sel_hi = VEC[i][7:6]; edge_sel_lo = VEC[i][5:4];
      cap_pin_lo = VEC[i][3]; cap_pin_hi = VEC[i][2];
      @(negedge clk);
      @(negedge clk);
      // R8 no flag before the third edge
      check(!capt_flag_lo && !capt_flag_hi, "R8 early flag",
            {capt_flag_hi, capt_flag_lo}, 0);
      snap = {cnt_hi, cnt_lo};
      @(negedge clk);
      check(capt_flag_hi == VEC[i][1], $sformatf("R5 R6 R7 vec%0d hi flag", i),
            capt_flag_hi, VEC[i][1]);
      check(capt_flag_lo == VEC[i][0], $sformatf("R5 R6 R7 vec%0d lo flag", i),
            capt_flag_lo, VEC[i][0]);
      check(capt_hi == (VEC[i][1] ? snap[31:16] : old_hi),
            $sformatf("R4 vec%0d hi value", i), capt_hi,
            VEC[i][1] ? snap[31:16] : old_hi);
      check(capt_lo == (VEC[i][0] ? snap[15:0] : old_lo),
            $sformatf("R4 vec%0d lo value", i), capt_lo,
            VEC[i][0] ? snap[15:0] : old_lo);
      @(negedge clk);
      // R8 flag lasts one cycle
      check(!capt_flag_lo && !capt_flag_hi, $sformatf("R8 vec%0d pulse", i),
            {capt_flag_hi, capt_flag_lo}, 0);
    end

    // R1 hold while disabled
    cnt_en = 1'b0;
    @(negedge clk);
    l0 = cnt_lo; h0 = cnt_hi;
    repeat (5) @(negedge clk);
    check(cnt_lo == l0 && cnt_hi == h0, "R1 hold", {cnt_hi, cnt_lo}, {h0, l0});
    cnt_en = 1'b1;

    // R4 R2 capture on the wrap clock
    incl_lo_into_hi = 1'b1; incl_hi_into_lo = 1'b1;
    edge_sel_lo = 2'b11; edge_sel_hi = 2'b11;
    cap_pin_lo = 1'b0; cap_pin_hi = 1'b0;
    repeat (5) @(negedge clk);
    while (cnt_lo != 16'hFFFD) @(negedge clk);
    h0 = cnt_hi;
    cap_pin_lo = 1'b1;
    repeat (3) @(negedge clk);
    check(capt_flag_lo && capt_flag_hi, "R4 wrap flags", {capt_flag_hi, capt_flag_lo}, 3);
    check(capt_lo == 16'hFFFF, "R4 wrap lo", capt_lo, 16'hFFFF);
    check(capt_hi == h0, "R4 wrap hi", capt_hi, h0);
    check(cnt_hi == h0 + 16'd1 && cnt_lo == 16'h0000, "R2 carry",
          {cnt_hi, cnt_lo}, {h0 + 16'd1, 16'h0000});

    // R3 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check({cnt_hi, cnt_lo, capt_hi, capt_lo} == 0 && !capt_flag_lo && !capt_flag_hi,
          "R3 mid-run reset", {capt_hi, capt_lo}, 0);
    rst = 1'b0;
    done = 1'b1;
    report();
  end
endmodule